// File: doc/BRIEF.md
# Boot-Time ROM Overlay Controller

This block decides, for the low region of the address map, whether a bus access goes to boot ROM or to RAM. A processor that fetches its initial stack pointer and reset entry address from address zero needs ROM there for a short window after reset. Later, the vector area must be writable RAM. The controller counts bus cycles from reset by watching the active-low address strobe. For the first `BOOT_CYCLES` cycles (default 4, covering two 32-bit words on a 16-bit bus), low-region accesses select ROM. After that they select RAM.

The address strobe is brought into the system clock domain through a synchroniser. A start detector turns each strobe assertion into a single pulse, and each pulse shifts a one into a chain that reset clears. An optional software hold bit comes out of reset set. While it stays set, the overlay lasts past the count. The overlay ends once the count has run out and the bit is clear, whichever of the two comes later. A build parameter selects a fixed-mirror variant instead. In that variant, reads of bytes 0 to 7 always come from ROM, writes there reach nothing, and the rest of the low region is always RAM.

The two outputs are active-high qualifiers. The rest of the memory decoder combines them with its own selects.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: After reset, with the strobe idle, both `rom_low_sel` and `ram_low_sel` are 0. The software hold bit resets to 1.
- R2: In the overlay variant (MIRROR_MODE=0), the 1st to 4th strobe assertions after reset select ROM for any low-region access (`addr[23:16]==0`), read or write.
- R3: From the 5th strobe assertion on, with the hold bit clear or the hold option absent, low-region accesses select RAM. Counting never returns the ROM to the low region until the next reset.
- R4: Writing `ctl_wdata` through a one-cycle `ctl_wr` pulse sets the hold bit. While it is 1, low-region accesses keep selecting ROM after the count. Clearing it ends the overlay, and setting it again restores it.
- R5: Clearing the hold bit before the 4th strobe does not shorten the overlay. The first four cycles still select ROM.
- R6: With SW_CTRL_EN=0, `ctl_wr` has no effect and the count alone ends the overlay.
- R7: In the fixed-mirror variant (MIRROR_MODE=1), reads of byte addresses 0 to 7 (`addr[15:3]==0` within the low region) select ROM, whatever the cycle count.
- R8: In the fixed-mirror variant, writes to byte addresses 0 to 7 select neither ROM nor RAM.
- R9: In the fixed-mirror variant, low-region addresses from 8 upward select RAM from the first cycle after reset.
- R10: Addresses outside the low region never assert either output.
- R11: `rom_low_sel` and `ram_low_sel` are never 1 together.
- R12: Outputs are asserted only while the synchronised strobe is asserted. A strobe held for many clocks counts as one bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| as_n | input | 1 | Active-low address strobe, asynchronous to clk |
| addr | input | 24 | Byte address of the current bus cycle |
| rw | input | 1 | 1 = read, 0 = write |
| ctl_wr | input | 1 | One-cycle write strobe for the hold bit |
| ctl_wdata | input | 1 | Value written to the hold bit |
| rom_low_sel | output | 1 | Low-region access goes to ROM |
| ram_low_sel | output | 1 | Low-region access goes to RAM |

## Verification
Three builds run side by side on the same stimulus: overlay with hold bit, overlay without it, and fixed mirror. Each step therefore shows how the variants differ on one access. The first sequence runs five and more cycles over vector addresses, a mirror-window write and an out-of-region address. It tells apart count expiry, the hold bit keeping ROM mapped, and the mirror ignoring writes. A second reset clears the hold bit early and holds the first strobe for twenty clocks. This separates "overlay ends by count only" from "cleared early" and from "long strobe counted more than once". Idle samples between cycles confirm that the outputs fall with the strobe.

// File: rtl/bov_pkg.sv
package bov_pkg;
  typedef struct packed {
    logic rom;
    logic ram;
  } low_sel_t;

  localparam int unsigned VEC_BYTES = 8;
endpackage

// File: rtl/bov_strobe_sync.sv
module bov_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  output logic bus_start,
  output logic bus_on
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   act_q, act_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ~as_n};
    act_d  = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      act_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      act_q  <= act_d;
    end
  end

  assign bus_start = sync_q[TOP] & ~act_q;
  assign bus_on    = sync_q[TOP] &  act_q;
endmodule

// File: rtl/bov_cycle_chain.sv
module bov_cycle_chain #(
  parameter int unsigned BOOT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  output logic count_done
);
  localparam int unsigned CHAIN_W = BOOT_CYCLES + 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = chain_q;
    if (bus_start) chain_d = {chain_q[CHAIN_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign count_done = chain_q[CHAIN_W-1];
endmodule

// File: rtl/bov_hold_bit.sv
module bov_hold_bit #(
  parameter bit SW_CTRL_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wdata,
  output logic hold
);
  if (SW_CTRL_EN) begin : g_hold
    logic hold_q, hold_d;
    always_comb begin
      hold_d = hold_q;
      if (ctl_wr) hold_d = ctl_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b1;
      else        hold_q <= hold_d;
    end
    assign hold = hold_q;
  end else begin : g_nohold
    logic unused_ctl;
    assign unused_ctl = ^{clk, rst_n, ctl_wr, ctl_wdata};
    assign hold = 1'b0;
  end
endmodule

// File: rtl/bov_low_decode.sv
module bov_low_decode
  import bov_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned LOW_AW      = 16,
  parameter bit          MIRROR_MODE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              bus_on,
  input  logic              overlay_on,
  output low_sel_t          sel
);
  localparam int unsigned MIR_AW = $clog2(VEC_BYTES);

  logic low_hit;
  assign low_hit = bus_on && (addr[ADDR_W-1:LOW_AW] == '0);

  if (MIRROR_MODE) begin : g_mirror
    logic in_vec;
    logic unused_ov;
    assign unused_ov = overlay_on;
    assign in_vec = (addr[LOW_AW-1:MIR_AW] == '0);
    always_comb begin
      sel.rom = low_hit &&  in_vec && rw;
      sel.ram = low_hit && !in_vec;
    end
  end else begin : g_overlay
    always_comb begin
      sel.rom = low_hit &&  overlay_on;
      sel.ram = low_hit && !overlay_on;
    end
  end
endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import bov_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned LOW_AW      = 16,
  parameter int unsigned BOOT_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          SW_CTRL_EN  = 1'b1,
  parameter bit          MIRROR_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              ctl_wr,
  input  logic              ctl_wdata,
  output logic              rom_low_sel,
  output logic              ram_low_sel
);
  logic     bus_start, bus_on, count_done, hold, overlay_on;
  low_sel_t sel;

  bov_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .as_n(as_n),
    .bus_start(bus_start), .bus_on(bus_on)
  );

  bov_cycle_chain #(.BOOT_CYCLES(BOOT_CYCLES)) u_chain (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .count_done(count_done)
  );

  bov_hold_bit #(.SW_CTRL_EN(SW_CTRL_EN)) u_hold (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .hold(hold)
  );

  assign overlay_on = ~count_done | hold;

  bov_low_decode #(.ADDR_W(ADDR_W), .LOW_AW(LOW_AW), .MIRROR_MODE(MIRROR_MODE)) u_dec (
    .addr(addr), .rw(rw), .bus_on(bus_on), .overlay_on(overlay_on), .sel(sel)
  );

  assign rom_low_sel = sel.rom;
  assign ram_low_sel = sel.ram;
endmodule

// File: rtl/bov_checker.sv
module bov_checker #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned LOW_AW      = 16,
  parameter bit          MIRROR_MODE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              as_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rw,
  input logic              rom_low_sel,
  input logic              ram_low_sel,
  input logic              count_done,
  input logic              overlay_on
);
  logic low_addr, vec_addr;
  assign low_addr = (addr[ADDR_W-1:LOW_AW] == '0);
  assign vec_addr = low_addr && (addr[LOW_AW-1:3] == '0);

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_low_sel && ram_low_sel)); // R11

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !low_addr |-> (!rom_low_sel && !ram_low_sel)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(as_n, 2) |-> (!rom_low_sel && !ram_low_sel)); // R12

  AST_COUNT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    count_done |=> count_done); // R3

  AST_NO_ROM_AFTER_OVERLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (MIRROR_MODE == 1'b0 && !overlay_on) |-> !rom_low_sel); // R3

  AST_MIRROR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (MIRROR_MODE == 1'b1 && vec_addr && !rw) |-> (!rom_low_sel && !ram_low_sel)); // R8

  AST_MIRROR_READ_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (MIRROR_MODE == 1'b1 && vec_addr && rw && (rom_low_sel || ram_low_sel)) |-> rom_low_sel); // R7
endmodule

bind boot_overlay_ctrl bov_checker #(
  .ADDR_W(ADDR_W), .LOW_AW(LOW_AW), .MIRROR_MODE(MIRROR_MODE)
) u_bov_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .rw(rw),
  .rom_low_sel(rom_low_sel), .ram_low_sel(ram_low_sel),
  .count_done(count_done), .overlay_on(overlay_on)
);

// File: tb/tb_boot_overlay_ctrl.sv
`timescale 1ns/100ps
module tb_boot_overlay_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        as_n;
  logic [23:0] addr;
  logic        rw;
  logic        ctl_wr, ctl_wdata;
  logic        rom_a, ram_a, rom_m, ram_m, rom_n, ram_n;

  always #2.5 clk = ~clk;

  boot_overlay_ctrl dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .rw(rw),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rom_low_sel(rom_a), .ram_low_sel(ram_a));
  boot_overlay_ctrl #(.MIRROR_MODE(1'b1)) dut_mir (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .rw(rw),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rom_low_sel(rom_m), .ram_low_sel(ram_m));
  boot_overlay_ctrl #(.SW_CTRL_EN(1'b0)) dut_nosw (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .rw(rw),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rom_low_sel(rom_n), .ram_low_sel(ram_n));

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  smp_ev;
  int    checks = 0;
  int    errors = 0;
  int    k = 0;
  logic  sw = 1'b1;

  // monitor: pops one expected item per sample event
  initial begin
    forever begin
      @(smp_ev);
      if (q.size() == 0) begin
        errors++; checks++;
        $display("FAIL scoreboard empty");
      end else begin
        item_t it;
        logic [5:0] act;
        it  = q.pop_front();
        act = {rom_a, ram_a, rom_m, ram_m, rom_n, ram_n};
        for (int i = 0; i < 3; i++) begin
          checks++;
          if (act[5-2*i -: 2] !== it.exp[5-2*i -: 2]) begin
            errors++;
            $display("FAIL %s inst%0d: actual rom/ram=%b expected=%b",
                     it.tag, i, act[5-2*i -: 2], it.exp[5-2*i -: 2]);
          end
        end
        checks++;
        if ((rom_a & ram_a) | (rom_m & ram_m) | (rom_n & ram_n)) begin
          errors++;
          $display("FAIL R11 both selects high: actual=%b expected=no pair 11", act);
        end
      end
    end
  end

  task automatic sample(input logic [5:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; as_n = 1'b1; addr = '0; rw = 1'b1; ctl_wr = 1'b0; ctl_wdata = 1'b0;
    k = 0; sw = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic set_hold(input logic v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
    sw = v;
  endtask

  // driver: one bus cycle, expected values from the requirements
  task automatic bus_cycle(input logic [23:0] a, input logic rd, input int hold_clks,
                           input string tag);
    logic low, vec, ov, ovn;
    logic [5:0] e;
    @(negedge clk);
    addr = a; rw = rd; as_n = 1'b0;
    k++;
    low = (a[23:16] == 0);
    vec = low && (a[15:3] == 0);
    ov  = (k <= 4) || sw;
    ovn = (k <= 4);
    e[5] = low && ov;   e[4] = low && !ov;
    e[3] = vec && rd;   e[2] = low && !vec;
    e[1] = low && ovn;  e[0] = low && !ovn;
    repeat (3 + hold_clks) @(posedge clk);
    @(negedge clk);
    sample(e, tag);
    as_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    sample(6'b0, "R12 idle after strobe");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    repeat (4) @(negedge clk);
    sample(6'b0, "R1 reset idle");
    bus_cycle(24'h000000, 1'b1, 0, "R2 R7 cycle1 read sp hi");
    bus_cycle(24'h000002, 1'b1, 0, "R2 cycle2 read");
    bus_cycle(24'h000004, 1'b0, 0, "R2 R8 cycle3 write vec");
    bus_cycle(24'h000006, 1'b1, 0, "R2 cycle4 read");
    bus_cycle(24'h000100, 1'b1, 0, "R4 R6 R3 cycle5 hold vs count");
    bus_cycle(24'h000008, 1'b1, 0, "R9 R4 cycle6");
    bus_cycle(24'h3F0000, 1'b0, 0, "R10 outside low");
    set_hold(1'b0);
    bus_cycle(24'h000010, 1'b1, 0, "R4 R3 hold cleared");
    set_hold(1'b1);
    bus_cycle(24'h000000, 1'b1, 0, "R4 hold set again R7");
    set_hold(1'b0);
    bus_cycle(24'h000002, 1'b0, 0, "R3 R8 write after release");

    do_reset();
    set_hold(1'b0);
    bus_cycle(24'h000000, 1'b1, 20, "R5 R12 long strobe cycle1");
    bus_cycle(24'h000002, 1'b1, 0, "R5 cycle2");
    bus_cycle(24'h00FFFE, 1'b0, 0, "R5 R9 cycle3 write");
    bus_cycle(24'h000004, 1'b1, 0, "R5 R7 cycle4");
    bus_cycle(24'h000006, 1'b1, 0, "R3 R7 cycle5 count expired");
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule